// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This block sits between a system's active-low memory chip enable and a battery-backed static RAM. While the supply is in tolerance it passes the chip enable straight through. When an external comparator reports that the supply has dropped below the power-fail trip level, it write-protects the memory by forcing the conditioned enable inactive (high). It also drives the select that moves the memory's power source from the main supply to the battery.

Protection is designed to avoid cutting a memory cycle in half. An access that is already under way when the failure is seen may finish, but only within a bounded window, measured in clock cycles. No new access is let through once the failure is detected. When the supply comes back, the enable stays inactive for a long recovery interval so that the processor can settle. A threshold-select input picks which of two power-fail comparator flags is used, one per trip level.

All comparator flags and the threshold select pass through a two-stage synchronizer before use. Both windows are parameters in clock cycles: the write-protect timeout `WP_CYC` and the recovery time `REC_CYC`. The block comes out of reset in the protected state with the recovery timer running.

Top module: `pfce_gate`

## Requirements
- R1: While the block is in its running state, `ce_out_n` equals `ce_raw_n` in the same cycle, with no register in the path.
- R2: When the selected power-fail flag is raised while `ce_raw_n` is high, `ce_out_n` is forced high from the third rising clock edge after the flag changes, whatever `ce_raw_n` does.
- R3: If `ce_raw_n` is low at the edge where the failure is acted on, `ce_out_n` keeps following `ce_raw_n` until `ce_raw_n` goes high. From then on `ce_out_n` is high.
- R4: Once `ce_out_n` has been forced high during a failure, it stays high for as long as the failure persists. A new falling edge on `ce_raw_n` is never passed through.
- R5: An access allowed to continue under R3 is passed for at most `WP_CYC` cycles, counting the edge that detects the failure. After that, `ce_out_n` is forced high even if `ce_raw_n` is still low.
- R6: After the failure clears, `ce_out_n` stays high until `REC_CYC` edges after the edge that sees the cleared flag (the third edge after the change). If the failure returns during this time, the recovery count starts again from the beginning once the failure next clears.
- R7: `thr_sel_i` = 0 selects `pf_lo_i` and ignores `pf_hi_i`. `thr_sel_i` = 1 selects `pf_hi_i` and ignores `pf_lo_i`.
- R8: `bat_sel_o` (1 = battery, 0 = main supply) follows `below_sw_i` with a lag of two rising edges.
- R9: A high `below_sw_i` counts as a power failure for gating, whatever the power-fail flags show.
- R10: During reset `ce_out_n` is high and `bat_sel_o` is 0. After reset is released with the supply valid, `ce_out_n` stays high for `REC_CYC` edges and then follows `ce_raw_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_raw_n | input | 1 | Raw active-low chip enable from the system |
| pf_lo_i | input | 1 | Power-fail flag from the lower trip-level comparator (1 = fail) |
| pf_hi_i | input | 1 | Power-fail flag from the higher trip-level comparator (1 = fail) |
| thr_sel_i | input | 1 | Trip-level select: 0 uses `pf_lo_i`, 1 uses `pf_hi_i` |
| below_sw_i | input | 1 | Supply below the battery switchover level (1 = below) |
| ce_out_n | output | 1 | Conditioned active-low chip enable to the memory |
| bat_sel_o | output | 1 | Memory supply select: 1 = battery, 0 = main supply |

## Verification
The pass-through path is combinational, so the bench changes `ce_raw_n` on a falling clock edge and samples `ce_out_n` one time unit later in the same cycle. Any comparator or select flag reaches the control state on the third rising edge after it changes, and `bat_sel_o` moves on the second. The bench therefore drives on falling edges and counts exactly that many edges before it samples. Both windows are checked at their boundaries: the last cycle that still passes and the first cycle that is forced, at `WP_CYC` edges for the drain timeout and at `3 + REC_CYC` edges for recovery. The bench computes these edge counts from the requirements.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

  // Control states of the gating controller
  typedef enum logic [1:0] {
    ST_RECOVER = 2'd0,  // supply valid, waiting out the recovery interval
    ST_RUN     = 2'd1,  // normal operation, enable passes through
    ST_DRAIN   = 2'd2,  // failure seen mid-access, letting it finish
    ST_HOLD    = 2'd3   // supply out of tolerance, enable forced off
  } pfce_state_e;

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        stg[STAGES-1] == $past(stg[STAGES-2])); // R8
    end
  endgenerate

endmodule

// File: rtl/pfce_timer.sv
module pfce_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= CNT_W'(RST_VAL);
    else if (load)                 cnt_q <= load_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // the controller must never ask for a count below zero
  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero); // R6

endmodule

// File: rtl/pfce_ctrl.sv
module pfce_ctrl
  import pfce_pkg::*;
#(
  parameter int WP_CYC  = 6000,
  parameter int REC_CYC = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_raw_n,
  input  logic fail,
  output logic ce_out_n
);

  localparam int WP_W  = (WP_CYC  > 1) ? $clog2(WP_CYC  + 1) : 1;
  localparam int REC_W = (REC_CYC > 1) ? $clog2(REC_CYC + 1) : 1;

  pfce_state_e st_q, st_d;
  logic wp_load, wp_dec, wp_zero;
  logic rc_load, rc_dec, rc_zero;

  // write-protect timeout counter
  pfce_timer #(.CNT_W(WP_W), .RST_VAL(0)) u_wp_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wp_load),
    .load_val (WP_W'(WP_CYC - 1)),
    .dec      (wp_dec),
    .zero     (wp_zero)
  );

  // recovery counter, preloaded at reset so power-up waits the full window
  pfce_timer #(.CNT_W(REC_W), .RST_VAL(REC_CYC - 1)) u_rc_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rc_load),
    .load_val (REC_W'(REC_CYC - 1)),
    .dec      (rc_dec),
    .zero     (rc_zero)
  );

  always_comb begin
    st_d    = st_q;
    wp_load = 1'b0;
    wp_dec  = 1'b0;
    rc_load = 1'b0;
    rc_dec  = 1'b0;
    unique case (st_q)
      ST_RECOVER: begin
        if (fail)         st_d = ST_HOLD;
        else if (rc_zero) st_d = ST_RUN;
        else              rc_dec = 1'b1;
      end
      ST_RUN: begin
        if (fail) begin
          if (!ce_raw_n) begin
            st_d    = ST_DRAIN;
            wp_load = 1'b1;
          end else begin
            st_d = ST_HOLD;
          end
        end
      end
      ST_DRAIN: begin
        if (ce_raw_n || wp_zero) st_d = ST_HOLD;
        else                     wp_dec = 1'b1;
      end
      ST_HOLD: begin
        if (!fail) begin
          st_d    = ST_RECOVER;
          rc_load = 1'b1;
        end
      end
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RECOVER;
    else        st_q <= st_d;
  end

  assign ce_out_n = (st_q == ST_RUN || st_q == ST_DRAIN) ? ce_raw_n : 1'b1;

  // length of the current drain phase, kept only for the bound check
  logic [WP_W:0] drain_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                drain_len_q <= '0;
    else if (st_q == ST_DRAIN) drain_len_q <= drain_len_q + 1'b1;
    else                       drain_len_q <= '0;
  end

  AST_IDLE_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && fail && ce_raw_n) |=> (st_q == ST_HOLD)); // R2

  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && ce_raw_n) |=> (st_q == ST_HOLD)); // R3

  AST_NO_NEW_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_out_n && fail && st_q != ST_RUN) |=> ce_out_n); // R4

  AST_DRAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> (drain_len_q < (WP_W+1)'(WP_CYC))); // R5

endmodule

// File: rtl/pfce_gate.sv
module pfce_gate #(
  parameter int WP_CYC      = 6000,
  parameter int REC_CYC     = 8000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_raw_n,
  input  logic pf_lo_i,
  input  logic pf_hi_i,
  input  logic thr_sel_i,
  input  logic below_sw_i,
  output logic ce_out_n,
  output logic bat_sel_o
);

  localparam int N_FLAGS = 4;

  logic [N_FLAGS-1:0] flags_raw, flags_s;
  logic below_s, lo_s, hi_s, thr_s;
  logic pf_sel, fail;

  assign flags_raw = {thr_sel_i, pf_hi_i, pf_lo_i, below_sw_i};

  pfce_sync #(.W(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flags_raw),
    .q     (flags_s)
  );

  assign below_s = flags_s[0];
  assign lo_s    = flags_s[1];
  assign hi_s    = flags_s[2];
  assign thr_s   = flags_s[3];

  assign pf_sel = thr_s ? hi_s : lo_s;
  // below switchover always implies loss of supply, whatever the trip flags say
  assign fail   = pf_sel | below_s;

  pfce_ctrl #(.WP_CYC(WP_CYC), .REC_CYC(REC_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_raw_n (ce_raw_n),
    .fail     (fail),
    .ce_out_n (ce_out_n)
  );

  assign bat_sel_o = below_s;

  AST_BATTERY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_sel_o && ce_out_n && $past(bat_sel_o)) |=> ce_out_n); // R9

endmodule

// File: tb/pfce_gate_bench.sv
module pfce_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WP  = 4;
  localparam int REC = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_raw_n, pf_lo, pf_hi, thr_sel, below_sw;
  logic ce_out_n, bat_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfce_gate #(.WP_CYC(WP), .REC_CYC(REC)) u_pfce_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_raw_n   (ce_raw_n),
    .pf_lo_i    (pf_lo),
    .pf_hi_i    (pf_hi),
    .thr_sel_i  (thr_sel),
    .below_sw_i (below_sw),
    .ce_out_n   (ce_out_n),
    .bat_sel_o  (bat_sel)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic restore_power();
    pf_lo = 1'b0; pf_hi = 1'b0; below_sw = 1'b0;
    step(3 + REC);
  endtask

  task automatic t_reset();
    ce_raw_n = 1'b0;
    step(REC - 1);
    chk("R10", "still recovering after reset", ce_out_n, 1'b1);
    step(1);
    chk("R10", "enable released after reset recovery", ce_out_n, 1'b0);
    ce_raw_n = 1'b1;
    step(1);
  endtask

  task automatic t_follow();
    ce_raw_n = 1'b0; #1 chk("R1", "follow low", ce_out_n, 1'b0);
    ce_raw_n = 1'b1; #1 chk("R1", "follow high", ce_out_n, 1'b1);
    step(1);
    ce_raw_n = 1'b0; #1 chk("R1", "follow low again", ce_out_n, 1'b0);
    step(3);
    chk("R1", "held low", ce_out_n, 1'b0);
    ce_raw_n = 1'b1; #1 chk("R1", "follow release", ce_out_n, 1'b1);
    step(1);
  endtask

  task automatic t_fail_idle();
    ce_raw_n = 1'b1;
    pf_lo = 1'b1;
    step(3);
    ce_raw_n = 1'b0; #1 chk("R2", "new access blocked at fail", ce_out_n, 1'b1);
    step(5);
    chk("R4", "still blocked while fail persists", ce_out_n, 1'b1);
    ce_raw_n = 1'b1; step(1);
    ce_raw_n = 1'b0; #1 chk("R4", "second falling edge blocked", ce_out_n, 1'b1);
    ce_raw_n = 1'b1;
    restore_power();
  endtask

  task automatic t_drain_finish();
    ce_raw_n = 1'b0;
    pf_lo = 1'b1;
    step(3);
    chk("R3", "access in progress continues", ce_out_n, 1'b0);
    step(1);
    chk("R3", "access still continuing", ce_out_n, 1'b0);
    ce_raw_n = 1'b1; #1 chk("R3", "access ended", ce_out_n, 1'b1);
    step(1);
    ce_raw_n = 1'b0; #1 chk("R4", "restart after drain blocked", ce_out_n, 1'b1);
    ce_raw_n = 1'b1;
    restore_power();
  endtask

  task automatic t_timeout();
    ce_raw_n = 1'b0;
    pf_lo = 1'b1;
    step(3);
    for (int j = 0; j < WP; j++) begin
      chk("R5", "within write-protect window", ce_out_n, 1'b0);
      step(1);
    end
    chk("R5", "forced after write-protect window", ce_out_n, 1'b1);
    step(2);
    chk("R5", "stays forced after timeout", ce_out_n, 1'b1);
    ce_raw_n = 1'b1;
    restore_power();
  endtask

  task automatic t_recovery();
    pf_lo = 1'b1;
    step(3);
    ce_raw_n = 1'b0;
    pf_lo = 1'b0;
    step(3 + REC - 1);
    chk("R6", "last recovery cycle still forced", ce_out_n, 1'b1);
    step(1);
    chk("R6", "released after recovery", ce_out_n, 1'b0);
    ce_raw_n = 1'b1;
    step(1);
    // interrupted recovery restarts the count
    pf_lo = 1'b1;
    step(3);
    pf_lo = 1'b0;
    step(3 + 4);
    pf_lo = 1'b1;
    step(3);
    pf_lo = 1'b0;
    ce_raw_n = 1'b0;
    step(3 + REC - 1);
    chk("R6", "restarted recovery still forced", ce_out_n, 1'b1);
    step(1);
    chk("R6", "released after restarted recovery", ce_out_n, 1'b0);
    ce_raw_n = 1'b1;
    step(1);
  endtask

  task automatic t_threshold();
    thr_sel = 1'b0;
    pf_hi = 1'b1;
    step(5);
    ce_raw_n = 1'b0; #1 chk("R7", "high flag ignored with select 0", ce_out_n, 1'b0);
    ce_raw_n = 1'b1;
    pf_hi = 1'b0;
    thr_sel = 1'b1;
    step(3);
    pf_lo = 1'b1;
    step(5);
    ce_raw_n = 1'b0; #1 chk("R7", "low flag ignored with select 1", ce_out_n, 1'b0);
    ce_raw_n = 1'b1;
    pf_lo = 1'b0;
    pf_hi = 1'b1;
    step(3);
    ce_raw_n = 1'b0; #1 chk("R7", "high flag used with select 1", ce_out_n, 1'b1);
    ce_raw_n = 1'b1;
    thr_sel = 1'b0;
    restore_power();
  endtask

  task automatic t_battery();
    ce_raw_n = 1'b1;
    below_sw = 1'b1;
    step(1);
    chk("R8", "select not yet moved", bat_sel, 1'b0);
    step(1);
    chk("R8", "select on battery", bat_sel, 1'b1);
    step(1);
    ce_raw_n = 1'b0; #1 chk("R9", "below switchover blocks access", ce_out_n, 1'b1);
    ce_raw_n = 1'b1;
    below_sw = 1'b0;
    step(1);
    chk("R8", "select still on battery", bat_sel, 1'b1);
    step(1);
    chk("R8", "select back on main supply", bat_sel, 1'b0);
    restore_power();
    ce_raw_n = 1'b0; #1 chk("R9", "access passes after return", ce_out_n, 1'b0);
    ce_raw_n = 1'b1;
    step(1);
  endtask

  initial begin
    rst_n = 1'b0;
    ce_raw_n = 1'b1; pf_lo = 1'b0; pf_hi = 1'b0; thr_sel = 1'b0; below_sw = 1'b0;
    step(3);
    ce_raw_n = 1'b0; #1
    chk("R10", "enable inactive in reset", ce_out_n, 1'b1);
    chk("R10", "main supply selected in reset", bat_sel, 1'b0);
    ce_raw_n = 1'b1;
    step(1);
    rst_n = 1'b1;
    t_reset();
    t_follow();
    t_fail_idle();
    t_drain_finish();
    t_timeout();
    t_recovery();
    t_threshold();
    t_battery();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule